// File: doc/BRIEF.md
# TMR Majority Voter with Fault Location

This block combines replicated copies of a K-bit signal into one trusted value. With three replicas it forms each output bit from the majority of the three matching input bits. It raises a flag whenever the replicas disagree. It also names the single replica that departs from the other two, or it signals that no single culprit exists because every pair of replicas differs. The logic is purely combinational, so the results follow the inputs within the same cycle.

A compile-time replica count selects one of three variants:

- **One replica:** a plain wire with no flags.
- **Two replicas:** detection only. The output follows replica 0 and any mismatch is flagged.
- **Three replicas:** full correction.

A second parameter chooses between one voted output and three identical voted copies. The three-copy form is meant for feeding the three lanes of a triplicated downstream stage.

Top module: `tmr_vote_unit`

## Requirements
- R1: With REPLICAS=3, bit n of every output copy equals the majority of bit n of rep_i[0], rep_i[1] and rep_i[2].
- R2: With REPLICAS=3, fault_any_o is 1 exactly when the three replica words are not all identical.
- R3: With REPLICAS=3, when two replica words are equal and the third differs, fault_loc_o has exactly one bit set and fault_multi_o is 0. Bit i of fault_loc_o stands for replica i (bit 0 for rep_i[0], bit 2 for rep_i[2]).
- R4: With REPLICAS=3, when all three replica words differ pairwise, fault_multi_o is 1 and fault_loc_o is 3'b111, while the output still carries the bitwise majority.
- R5: When all replicas in use are identical, fault_loc_o is 3'b000 and fault_multi_o is 0.
- R6: With COPIES=3, all three entries of out_o carry the same voted word.
- R7: With REPLICAS=2, out_o equals rep_i[0], and fault_any_o is 1 exactly when rep_i[0] differs from rep_i[1] in any bit. fault_loc_o stays 3'b000 and fault_multi_o stays 0. rep_i[2] has no effect on any output.
- R8: With REPLICAS=1, out_o equals rep_i[0] and every fault output stays 0. rep_i[1] and rep_i[2] have no effect on any output.
- R9: The block holds no state: every output reflects the present inputs within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rep_i | input | 3 x WIDTH | Replica words; index i is replica i |
| out_o | output | COPIES x WIDTH | Voted word, one entry per output copy |
| fault_any_o | output | 1 | Replicas in use are not unanimous |
| fault_loc_o | output | 3 | One-hot name of the deviating replica, 3'b111 when none can be named |
| fault_multi_o | output | 1 | Every pair of replicas differs |

## Verification
The hardest case to reach is the one where all three words differ pairwise but every bit still has a clear majority. In that case the voted word is valid even though no replica can be blamed. The stimulus builds it from three patterns whose bits interleave, such as 0xF0, 0xCC and 0xAA. This exercises R4, with a majority of 0xE8, alongside R1. A sweep of generated words then forces differences into single bits at varied positions, so that the word-level location logic is checked against faults that touch only one bit.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;
    localparam int unsigned SLOTS = 3;
    typedef logic [SLOTS-1:0] loc_t;
    localparam loc_t LOC_NONE = '0;
    localparam loc_t LOC_ALL  = '1;
endpackage

// File: rtl/tmr_majority_bits.sv
module tmr_majority_bits #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    output logic [WIDTH-1:0] maj_o
);
    for (genvar n = 0; n < WIDTH; n++) begin : g_bit
        assign maj_o[n] = (a_i[n] & b_i[n]) | (a_i[n] & c_i[n]) | (b_i[n] & c_i[n]);
    end
endmodule

// File: rtl/tmr_pair_compare.sv
module tmr_pair_compare #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             differ_o
);
    logic [WIDTH-1:0] diff_bits;
    assign diff_bits = a_i ^ b_i;
    assign differ_o  = |diff_bits;
endmodule

// File: rtl/tmr_fault_locator.sv
module tmr_fault_locator
    import tmr_vote_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [SLOTS-1:0][WIDTH-1:0] rep_i,
    input  logic [WIDTH-1:0]            voted_i,
    output logic                        any_o,
    output loc_t                        loc_o,
    output logic                        multi_o
);
    logic d01, d12, d02;
    loc_t dev;

    tmr_pair_compare #(.WIDTH(WIDTH)) u_c01 (.a_i(rep_i[0]), .b_i(rep_i[1]), .differ_o(d01));
    tmr_pair_compare #(.WIDTH(WIDTH)) u_c12 (.a_i(rep_i[1]), .b_i(rep_i[2]), .differ_o(d12));
    tmr_pair_compare #(.WIDTH(WIDTH)) u_c02 (.a_i(rep_i[0]), .b_i(rep_i[2]), .differ_o(d02));

    for (genvar s = 0; s < SLOTS; s++) begin : g_dev
        tmr_pair_compare #(.WIDTH(WIDTH)) u_dev (
            .a_i(rep_i[s]), .b_i(voted_i), .differ_o(dev[s])
        );
    end

    always_comb begin
        any_o   = d01 | d12;
        multi_o = d01 & d12 & d02;
        loc_o   = multi_o ? LOC_ALL : dev;
    end
endmodule

// File: rtl/tmr_vote_unit.sv
module tmr_vote_unit
    import tmr_vote_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned REPLICAS = 3,
    parameter int unsigned COPIES   = 3
) (
    input  logic [SLOTS-1:0][WIDTH-1:0]  rep_i,
    output logic [COPIES-1:0][WIDTH-1:0] out_o,
    output logic                         fault_any_o,
    output logic [SLOTS-1:0]             fault_loc_o,
    output logic                         fault_multi_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             any;
        loc_t             loc;
        logic             multi;
    } vote_res_t;

    vote_res_t res_d;

    if (REPLICAS == 3) begin : g_tmr
        logic [WIDTH-1:0] maj;
        logic             any_t;
        loc_t             loc_t_s;
        logic             multi_t;

        tmr_majority_bits #(.WIDTH(WIDTH)) u_maj (
            .a_i(rep_i[0]), .b_i(rep_i[1]), .c_i(rep_i[2]), .maj_o(maj)
        );
        tmr_fault_locator #(.WIDTH(WIDTH)) u_loc (
            .rep_i(rep_i), .voted_i(maj),
            .any_o(any_t), .loc_o(loc_t_s), .multi_o(multi_t)
        );

        always_comb begin
            res_d.word  = maj;
            res_d.any   = any_t;
            res_d.loc   = loc_t_s;
            res_d.multi = multi_t;
        end
    end else if (REPLICAS == 2) begin : g_dmr
        logic             d01;
        logic [WIDTH-1:0] unused_rep2;
        assign unused_rep2 = rep_i[2];

        tmr_pair_compare #(.WIDTH(WIDTH)) u_cmp (
            .a_i(rep_i[0]), .b_i(rep_i[1]), .differ_o(d01)
        );

        always_comb begin
            res_d.word  = rep_i[0];
            res_d.any   = d01;
            res_d.loc   = LOC_NONE;
            res_d.multi = 1'b0;
        end
    end else begin : g_single
        logic [2*WIDTH-1:0] unused_rep12;
        assign unused_rep12 = {rep_i[2], rep_i[1]};

        always_comb begin
            res_d.word  = rep_i[0];
            res_d.any   = 1'b0;
            res_d.loc   = LOC_NONE;
            res_d.multi = 1'b0;
        end
    end

    for (genvar k = 0; k < COPIES; k++) begin : g_copy
        assign out_o[k] = res_d.word;
    end

    assign fault_any_o   = res_d.any;
    assign fault_loc_o   = res_d.loc;
    assign fault_multi_o = res_d.multi;
endmodule

// File: rtl/tmr_vote_checker.sv
module tmr_vote_checker #(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned REPLICAS = 3,
    parameter int unsigned COPIES   = 3
) (
    input logic [2:0][WIDTH-1:0]        rep_i,
    input logic [COPIES-1:0][WIDTH-1:0] out_o,
    input logic                         fault_any_o,
    input logic [2:0]                   fault_loc_o,
    input logic                         fault_multi_o
);
    for (genvar k = 1; k < COPIES; k++) begin : g_cp
        always_comb begin
            if (!$isunknown(out_o))
                assert_copies_match_R6: assert (out_o[k] == out_o[0]);
        end
    end

    if (REPLICAS == 3) begin : g_t
        always_comb begin
            if (!$isunknown({rep_i, out_o, fault_any_o, fault_loc_o, fault_multi_o})) begin
                if (rep_i[0] == rep_i[1])
                    assert_pair_wins_R1: assert (out_o[0] == rep_i[0]);
                if (rep_i[1] == rep_i[2])
                    assert_pair_wins12_R1: assert (out_o[0] == rep_i[1]);
                assert_any_flag_R2: assert (fault_any_o ==
                    ((rep_i[0] != rep_i[1]) || (rep_i[0] != rep_i[2])));
                assert_loc_single_R3: assert (fault_multi_o || $countones(fault_loc_o) <= 1);
                assert_multi_all_R4: assert (!fault_multi_o || fault_loc_o == 3'b111);
                assert_clean_R5: assert (fault_any_o || (fault_loc_o == 3'b000 && !fault_multi_o));
            end
        end
    end else if (REPLICAS == 2) begin : g_d
        always_comb begin
            if (!$isunknown({rep_i[1:0], out_o, fault_any_o, fault_loc_o, fault_multi_o})) begin
                assert_follow0_R7: assert (out_o[0] == rep_i[0]);
                assert_noloc_R7: assert (fault_loc_o == 3'b000 && !fault_multi_o);
                assert_dmr_flag_R7: assert (fault_any_o == (rep_i[0] != rep_i[1]));
            end
        end
    end else begin : g_s
        always_comb begin
            if (!$isunknown({rep_i[0], out_o, fault_any_o, fault_loc_o, fault_multi_o})) begin
                assert_pass_R8: assert (out_o[0] == rep_i[0]);
                assert_quiet_R8: assert (!fault_any_o && fault_loc_o == 3'b000 && !fault_multi_o);
            end
        end
    end
endmodule

bind tmr_vote_unit tmr_vote_checker #(
    .WIDTH(WIDTH), .REPLICAS(REPLICAS), .COPIES(COPIES)
) u_chk (
    .rep_i(rep_i), .out_o(out_o), .fault_any_o(fault_any_o),
    .fault_loc_o(fault_loc_o), .fault_multi_o(fault_multi_o)
);

// File: tb/sim_tmr_vote_unit.sv
module sim_tmr_vote_unit;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0][W-1:0] rep;
    logic [2:0][W-1:0] out3;
    logic [0:0][W-1:0] out2, out1;
    logic any3, multi3, any2, multi2, any1, multi1;
    logic [2:0] loc3, loc2, loc1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    tmr_vote_unit #(.WIDTH(W), .REPLICAS(3), .COPIES(3)) u0 (
        .rep_i(rep), .out_o(out3), .fault_any_o(any3),
        .fault_loc_o(loc3), .fault_multi_o(multi3));
    tmr_vote_unit #(.WIDTH(W), .REPLICAS(2), .COPIES(1)) u2 (
        .rep_i(rep), .out_o(out2), .fault_any_o(any2),
        .fault_loc_o(loc2), .fault_multi_o(multi2));
    tmr_vote_unit #(.WIDTH(W), .REPLICAS(1), .COPIES(1)) u1 (
        .rep_i(rep), .out_o(out1), .fault_any_o(any1),
        .fault_loc_o(loc1), .fault_multi_o(multi1));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        @(negedge clk);
        rep = {c, b, a};
        #2;
    endtask

    function automatic logic [W-1:0] maj(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] r;
        for (int n = 0; n < W; n++)
            r[n] = (a[n] + b[n] + c[n]) >= 2;
        return r;
    endfunction

    task automatic t_reset_state;
        @(negedge clk); #2;
        check("R5 reset out", out3[0], 8'h00);
        check("R5 reset loc", {any3, loc3, multi3}, 5'b0);
    endtask

    task automatic t_unanimous;
        apply(8'h5A, 8'h5A, 8'h5A);
        check("R1 unanimous out", out3[0], 8'h5A);
        check("R2 unanimous any", any3, 1'b0);
        check("R5 unanimous loc/multi", {loc3, multi3}, 4'b0000);
    endtask

    task automatic t_single_fault;
        for (int s = 0; s < 3; s++) begin
            logic [2:0][W-1:0] v;
            v = {8'h3C, 8'h3C, 8'h3C};
            v[s] = 8'h3C ^ (8'h01 << (s * 3));
            apply(v[0], v[1], v[2]);
            check("R1 single fault out", out3[0], 8'h3C);
            check("R2 single fault any", any3, 1'b1);
            check("R3 single fault loc", loc3, 3'b001 << s);
            check("R3 single fault multi", multi3, 1'b0);
        end
    endtask

    task automatic t_multi;
        apply(8'hF0, 8'hCC, 8'hAA);
        check("R4 multi out", out3[0], 8'hE8);
        check("R4 multi flag", multi3, 1'b1);
        check("R4 multi loc", loc3, 3'b111);
        check("R2 multi any", any3, 1'b1);
    endtask

    task automatic t_copies;
        apply(8'h81, 8'h81, 8'h7E);
        check("R6 copy1", out3[1], 8'h81);
        check("R6 copy2", out3[2], 8'h81);
    endtask

    task automatic t_sweep;
        logic [W-1:0] a, b, c;
        logic [W-1:0] e;
        logic ea, em;
        logic [2:0] el;
        for (int i = 0; i < 40; i++) begin
            a = W'(i * 37 + 11);
            b = (i % 3 == 0) ? a : (a ^ W'(1 << (i % W)));
            c = (i % 4 == 1) ? a : W'(i * 91 + 5);
            apply(a, b, c);
            e  = maj(a, b, c);
            ea = !(a == b && b == c);
            em = (a != b) && (b != c) && (a != c);
            el = em ? 3'b111 : {c != e, b != e, a != e};
            check("R1 sweep out", out3[0], e);
            check("R2 sweep any", any3, ea);
            check("R4 sweep loc", {loc3, multi3}, {el, em});
        end
    endtask

    task automatic t_two_rep;
        apply(8'h12, 8'h12, 8'hFF);
        check("R7 dmr equal out", out2[0], 8'h12);
        check("R7 dmr rep2 ignored", {any2, loc2, multi2}, 5'b0);
        apply(8'h12, 8'h13, 8'h12);
        check("R7 dmr mismatch out", out2[0], 8'h12);
        check("R7 dmr mismatch flags", {any2, loc2, multi2}, 5'b10000);
    endtask

    task automatic t_one_rep;
        apply(8'hA5, 8'h00, 8'hFF);
        check("R8 single out", out1[0], 8'hA5);
        check("R8 single flags", {any1, loc1, multi1}, 5'b0);
    endtask

    task automatic t_comb;
        @(negedge clk);
        rep = {8'h44, 8'h44, 8'h44};
        #1;
        check("R9 same-cycle a", out3[0], 8'h44);
        rep = {8'h44, 8'h99, 8'h99};
        #1;
        check("R9 same-cycle b", {out3[0], loc3}, {8'h99, 3'b100});
    endtask

    initial begin
        rep = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_unanimous();
        t_single_fault();
        t_multi();
        t_copies();
        t_sweep();
        t_two_rep();
        t_one_rep();
        t_comb();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule